// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This controller sits next to a simple processor core and handles every change of control flow that the core does not ask for itself. Three kinds of event come in: external request lines, a synchronous fault flag from the instruction that is retiring, and a supervisor-call request. Each event is accepted only on a cycle where the core reports a completed instruction. On acceptance the sequencer records where execution must resume and what the privilege mode was, forces the mode bit to monitor, fetches the handler address from a vector table at the bottom of memory through a one-cycle synchronous read port, and hands that address to the fetch unit as a redirect.

While a handler runs, external requests are held back. A request that arrives during that time is latched as a pending bit and stays there until software acknowledges it by cause number. A return instruction issued in monitor mode redirects fetch to the saved address, restores the saved mode and lifts the mask. A return attempted from user mode performs no return and is turned into a privilege-violation trap. Cause codes are fixed: 0 is privilege violation, 1 is fault, 2 is supervisor call, and 3+k is external line k.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the mode bit is monitor (mode_o = 0), nothing is pending, the mask is off, stall_o and redirect_o are low, and the saved return address and cause are zero.
- R2: Accepting any trap sets mode_o to 0 (monitor) on the accepting clock edge, before the handler redirect appears.
- R3: A trap is accepted only on a cycle where retire_i is high and stall_o is low; pending requests with no retiring instruction cause no stall and no redirect.
- R4: On entry epc_o takes cur_pc_i for a fault or a privilege violation, and next_pc_i for a supervisor call or an external request.
- R5: The cycle after acceptance the block issues vec_rd_en_o with vec_addr_o = VEC_BASE + cause (a word index); the cycle after that it raises redirect_o for one cycle with redirect_pc_o equal to the word read back.
- R6: From entry until a return is accepted, external requests are not taken, even when instructions retire.
- R7: A high level on irq_i[k] for one cycle sets pending bit k; it stays set until ack_i is high with ack_cause_i = 3+k, and a simultaneous set wins over the clear.
- R8: A return (rti_i with retire_i) in monitor mode raises redirect_o on the next cycle with redirect_pc_o = epc_o, restores the mode saved at entry (user for traps taken from user code), and lifts the mask.
- R9: A return attempted in user mode performs no return: it is taken as cause 0 with epc_o set to that instruction's cur_pc_i, and mode_o becomes 0.
- R10: When several events meet on one retiring instruction, a fault wins over a supervisor call, which wins over external requests; among external lines the lowest index wins.
- R11: stall_o is high from the cycle after acceptance through the redirect cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | Core completed an instruction this cycle (instruction boundary) |
| cur_pc_i | input | ADDR_W | Address of the retiring instruction |
| next_pc_i | input | ADDR_W | Address of the instruction that would follow |
| fault_i | input | 1 | Retiring instruction raised a synchronous fault |
| svc_i | input | 1 | Retiring instruction is a supervisor call |
| rti_i | input | 1 | Retiring instruction is a return from trap |
| irq_i | input | NUM_IRQ | External request lines |
| ack_i | input | 1 | Acknowledge pulse from the handler |
| ack_cause_i | input | CAUSE_W | Cause number being acknowledged |
| vec_rd_en_o | output | 1 | Vector table read strobe |
| vec_addr_o | output | ADDR_W | Vector table word address |
| vec_rdata_i | input | ADDR_W | Vector word, valid one cycle after the strobe |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | ADDR_W | Address to fetch from when redirect_o is high |
| stall_o | output | 1 | Core must hold while the sequencer is busy |
| mode_o | output | 1 | Mode bit: 0 monitor, 1 user |
| irq_masked_o | output | 1 | External requests are masked (handler active) |
| pending_o | output | NUM_IRQ | Latched external requests |
| cause_o | output | CAUSE_W | Cause of the last accepted trap |
| epc_o | output | ADDR_W | Saved return address |

## Verification
The bench builds the block with NUM_IRQ = 8, ADDR_W = 16 and VEC_BASE = 0, so cause codes run from 0 to 10 and need the full four-bit cause field. Eight lines are enough to place requests at the lowest and highest index, in sparse and full patterns, which exercises the lowest-index pick and the fault-over-call-over-request order on a single retiring instruction. The vector memory returns a word derived from the address it was given, so a wrong table index shows up as a wrong redirect address.

// File: rtl/tes_pkg.sv
package tes_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_VREAD,
    ST_VWAIT,
    ST_RETURN
  } seq_state_e;

  typedef enum logic [2:0] {
    TK_NONE,
    TK_PRIV,
    TK_FAULT,
    TK_SVC,
    TK_RTI,
    TK_IRQ
  } trap_kind_e;

  localparam logic MODE_MONITOR = 1'b0;
  localparam logic MODE_USER    = 1'b1;

  localparam int CAUSE_PRIV  = 0;
  localparam int CAUSE_FAULT = 1;
  localparam int CAUSE_SVC   = 2;
  localparam int CAUSE_IRQ0  = 3;

  function automatic logic kind_is_entry(input trap_kind_e k);
    return (k == TK_PRIV) || (k == TK_FAULT) || (k == TK_SVC) || (k == TK_IRQ);
  endfunction

  function automatic logic kind_saves_current(input trap_kind_e k);
    return (k == TK_PRIV) || (k == TK_FAULT);
  endfunction

endpackage

// File: rtl/tes_pending.sv
module tes_pending
  import tes_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               ack_i,
  input  logic [CAUSE_W-1:0] ack_cause_i,
  output logic [NUM_IRQ-1:0] pend_o
);

  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] clear_hit;

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    assign clear_hit[k] = ack_i && (ack_cause_i == CAUSE_W'(CAUSE_IRQ0 + k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q[k] <= 1'b0;
      else if (irq_i[k])   pend_q[k] <= 1'b1;
      else if (clear_hit[k]) pend_q[k] <= 1'b0;
    end

    assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i[k] |=> pend_q[k]);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_hit[k] && !irq_i[k]) |=> !pend_q[k]);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[k] && !clear_hit[k]) |=> pend_q[k]);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/tes_arbiter.sv
module tes_arbiter
  import tes_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               boundary_i,
  input  logic               fault_i,
  input  logic               svc_i,
  input  logic               rti_i,
  input  logic               mode_i,
  input  logic               mask_i,
  input  logic [NUM_IRQ-1:0] pend_i,
  output trap_kind_e         kind_o,
  output logic [IDX_W-1:0]   irq_idx_o
);

  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_IRQ-1:0] v);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (v[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  logic irq_eligible;

  assign irq_eligible = !mask_i && (|pend_i);
  assign irq_idx_o    = lowest_set(pend_i);

  always_comb begin
    kind_o = TK_NONE;
    if (boundary_i) begin
      if (fault_i)                          kind_o = TK_FAULT;
      else if (rti_i && mode_i == MODE_USER) kind_o = TK_PRIV;
      else if (svc_i)                       kind_o = TK_SVC;
      else if (rti_i)                       kind_o = TK_RTI;
      else if (irq_eligible)                kind_o = TK_IRQ;
    end
  end

endmodule

// File: rtl/tes_ctrl.sv
module tes_ctrl
  import tes_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CAUSE_W  = 4,
  parameter int VEC_BASE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  trap_kind_e         kind_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [ADDR_W-1:0]  save_addr_i,
  input  logic [ADDR_W-1:0]  vec_rdata_i,
  output logic               busy_o,
  output logic               mode_o,
  output logic               in_service_o,
  output logic [ADDR_W-1:0]  epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               vec_rd_en_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic               redirect_o,
  output logic [ADDR_W-1:0]  redirect_pc_o
);

  function automatic logic [ADDR_W-1:0] vec_word(input logic [CAUSE_W-1:0] c);
    return ADDR_W'(VEC_BASE) + ADDR_W'(c);
  endfunction

  seq_state_e         state_q;
  logic               mode_q;
  logic               prev_mode_q;
  logic               in_service_q;
  logic [ADDR_W-1:0]  epc_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               entry_take;
  logic               return_take;

  assign entry_take  = kind_is_entry(kind_i);
  assign return_take = (kind_i == TK_RTI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      mode_q       <= MODE_MONITOR;
      prev_mode_q  <= MODE_USER;
      in_service_q <= 1'b0;
      epc_q        <= '0;
      cause_q      <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (entry_take) begin
            state_q      <= ST_VREAD;
            prev_mode_q  <= mode_q;
            mode_q       <= MODE_MONITOR;
            epc_q        <= save_addr_i;
            cause_q      <= cause_i;
            in_service_q <= 1'b1;
          end else if (return_take) begin
            state_q      <= ST_RETURN;
            mode_q       <= prev_mode_q;
            in_service_q <= 1'b0;
          end
        end
        ST_VREAD:  state_q <= ST_VWAIT;
        ST_VWAIT:  state_q <= ST_IDLE;
        ST_RETURN: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign mode_o        = mode_q;
  assign in_service_o  = in_service_q;
  assign epc_o         = epc_q;
  assign cause_o       = cause_q;
  assign vec_rd_en_o   = (state_q == ST_VREAD);
  assign vec_addr_o    = vec_word(cause_q);
  assign redirect_o    = (state_q == ST_VWAIT) || (state_q == ST_RETURN);
  assign redirect_pc_o = (state_q == ST_VWAIT) ? vec_rdata_i : epc_q;

  assert_monitor_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_take |=> (mode_q == MODE_MONITOR) && vec_rd_en_o);

  assert_read_then_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd_en_o |=> redirect_o && !vec_rd_en_o);

  assert_return_restores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    return_take |=> (mode_q == $past(prev_mode_q)) && !in_service_q && redirect_o);

  assert_redirect_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o);

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import tes_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int ADDR_W   = 16,
  parameter int VEC_BASE = 0,
  localparam int CAUSE_W = $clog2(NUM_IRQ + CAUSE_IRQ0)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               retire_i,
  input  logic [ADDR_W-1:0]  cur_pc_i,
  input  logic [ADDR_W-1:0]  next_pc_i,
  input  logic               fault_i,
  input  logic               svc_i,
  input  logic               rti_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               ack_i,
  input  logic [CAUSE_W-1:0] ack_cause_i,
  output logic               vec_rd_en_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  input  logic [ADDR_W-1:0]  vec_rdata_i,
  output logic               redirect_o,
  output logic [ADDR_W-1:0]  redirect_pc_o,
  output logic               stall_o,
  output logic               mode_o,
  output logic               irq_masked_o,
  output logic [NUM_IRQ-1:0] pending_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [ADDR_W-1:0]  epc_o
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic               busy;
  logic               boundary;
  logic               in_service;
  logic [NUM_IRQ-1:0] pend;
  trap_kind_e         kind;
  logic [IDX_W-1:0]   irq_idx;
  logic [CAUSE_W-1:0] cause_sel;
  logic [ADDR_W-1:0]  save_addr;

  assign boundary = retire_i && !busy;

  tes_pending #(
    .NUM_IRQ (NUM_IRQ),
    .CAUSE_W (CAUSE_W)
  ) u_pending (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_i       (irq_i),
    .ack_i       (ack_i),
    .ack_cause_i (ack_cause_i),
    .pend_o      (pend)
  );

  tes_arbiter #(
    .NUM_IRQ (NUM_IRQ)
  ) u_arbiter (
    .boundary_i (boundary),
    .fault_i    (fault_i),
    .svc_i      (svc_i),
    .rti_i      (rti_i),
    .mode_i     (mode_o),
    .mask_i     (in_service),
    .pend_i     (pend),
    .kind_o     (kind),
    .irq_idx_o  (irq_idx)
  );

  always_comb begin
    case (kind)
      TK_PRIV:  cause_sel = CAUSE_W'(CAUSE_PRIV);
      TK_FAULT: cause_sel = CAUSE_W'(CAUSE_FAULT);
      TK_SVC:   cause_sel = CAUSE_W'(CAUSE_SVC);
      TK_IRQ:   cause_sel = CAUSE_W'(CAUSE_IRQ0) + CAUSE_W'(irq_idx);
      default:  cause_sel = '0;
    endcase
  end

  assign save_addr = kind_saves_current(kind) ? cur_pc_i : next_pc_i;

  tes_ctrl #(
    .ADDR_W   (ADDR_W),
    .CAUSE_W  (CAUSE_W),
    .VEC_BASE (VEC_BASE)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .kind_i        (kind),
    .cause_i       (cause_sel),
    .save_addr_i   (save_addr),
    .vec_rdata_i   (vec_rdata_i),
    .busy_o        (busy),
    .mode_o        (mode_o),
    .in_service_o  (in_service),
    .epc_o         (epc_o),
    .cause_o       (cause_o),
    .vec_rd_en_o   (vec_rd_en_o),
    .vec_addr_o    (vec_addr_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  assign stall_o      = busy;
  assign irq_masked_o = in_service;
  assign pending_o    = pend;

  assert_boundary_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != TK_NONE) |-> (retire_i && !stall_o));

  assert_masked_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_masked_o |-> (kind != TK_IRQ));

  assert_user_return_traps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && rti_i && !fault_i && mode_o == MODE_USER)
      |=> (cause_o == CAUSE_W'(CAUSE_PRIV)) && (mode_o == MODE_MONITOR) && !redirect_o);

  assert_fault_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && fault_i) |=> (cause_o == CAUSE_W'(CAUSE_FAULT)) && (epc_o == $past(cur_pc_i)));

  assert_stall_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && kind == TK_NONE) |=> !stall_o);

endmodule

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;

  localparam int NUM_IRQ = 8;
  localparam int ADDR_W  = 16;
  localparam int CW      = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              retire = 1'b0;
  logic [ADDR_W-1:0] cur_pc = '0;
  logic [ADDR_W-1:0] next_pc = '0;
  logic              fault = 1'b0;
  logic              svc = 1'b0;
  logic              rti = 1'b0;
  logic [NUM_IRQ-1:0] irq = '0;
  logic              ack = 1'b0;
  logic [CW-1:0]     ack_cause = '0;
  logic              vec_rd_en;
  logic [ADDR_W-1:0] vec_addr;
  logic [ADDR_W-1:0] vec_rdata = '0;
  logic              redirect;
  logic [ADDR_W-1:0] redirect_pc;
  logic              stall;
  logic              mode;
  logic              masked;
  logic [NUM_IRQ-1:0] pending;
  logic [CW-1:0]     cause;
  logic [ADDR_W-1:0] epc;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trap_entry_seq #(
    .NUM_IRQ  (NUM_IRQ),
    .ADDR_W   (ADDR_W),
    .VEC_BASE (0)
  ) u_trap_entry_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .retire_i      (retire),
    .cur_pc_i      (cur_pc),
    .next_pc_i     (next_pc),
    .fault_i       (fault),
    .svc_i         (svc),
    .rti_i         (rti),
    .irq_i         (irq),
    .ack_i         (ack),
    .ack_cause_i   (ack_cause),
    .vec_rd_en_o   (vec_rd_en),
    .vec_addr_o    (vec_addr),
    .vec_rdata_i   (vec_rdata),
    .redirect_o    (redirect),
    .redirect_pc_o (redirect_pc),
    .stall_o       (stall),
    .mode_o        (mode),
    .irq_masked_o  (masked),
    .pending_o     (pending),
    .cause_o       (cause),
    .epc_o         (epc)
  );

  // Vector memory: one-cycle synchronous read, word depends on the address
  always_ff @(posedge clk) begin
    if (vec_rd_en) vec_rdata <= 16'hA000 + {vec_addr[11:0], 4'h0};
  end

  function automatic logic [ADDR_W-1:0] exp_vec(input int c);
    return 16'hA000 + ADDR_W'(c * 16);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_retire(input logic [ADDR_W-1:0] pc, input bit f, input bit s, input bit r);
    retire = 1'b1; cur_pc = pc; next_pc = pc + 1; fault = f; svc = s; rti = r;
    @(negedge clk);
    retire = 1'b0; fault = 1'b0; svc = 1'b0; rti = 1'b0;
  endtask

  task automatic wait_redirect(output int n);
    n = 1;
    while (!redirect && n < 10) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic ack_all();
    for (int k = 0; k < NUM_IRQ; k++) begin
      ack = 1'b1; ack_cause = CW'(3 + k);
      @(negedge clk);
    end
    ack = 1'b0;
  endtask

  task automatic check_entry(input string tag, input int exp_cause, input int exp_epc);
    int n;
    check(stall == 1'b1, {"R11 ", tag}, stall, 1);
    check(mode == 1'b0, {"R2 ", tag}, mode, 0);
    wait_redirect(n);
    check(n == 2, {"R5 latency ", tag}, n, 2);
    check(redirect_pc == exp_vec(exp_cause), {"R5 vector ", tag}, redirect_pc, exp_vec(exp_cause));
    check(cause == CW'(exp_cause), {"R10 cause ", tag}, cause, exp_cause);
    check(epc == ADDR_W'(exp_epc), {"R4 epc ", tag}, epc, exp_epc);
    check(stall == 1'b1 && masked == 1'b1, {"R11/R6 ", tag}, {stall, masked}, 3);
    @(negedge clk);
  endtask

  task automatic do_return(input string tag, input int exp_pc);
    int n;
    do_retire(16'h0040, 1'b0, 1'b0, 1'b1);
    wait_redirect(n);
    check(n == 1, {"R8 latency ", tag}, n, 1);
    check(redirect_pc == ADDR_W'(exp_pc), {"R8 target ", tag}, redirect_pc, exp_pc);
    check(mode == 1'b1 && masked == 1'b0, {"R8 mode/mask ", tag}, {mode, masked}, 2);
    @(negedge clk);
  endtask

  task automatic quiet(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(!redirect && !stall, tag, {redirect, stall}, 0);
    end
  endtask

  // irq pattern, fault, svc, expected cause, epc uses next_pc
  typedef struct packed {
    logic [7:0] irqs;
    logic       f;
    logic       s;
    logic [3:0] cause;
    logic       use_next;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    row_t'{8'h01, 1'b0, 1'b0, 4'd3,  1'b1},
    row_t'{8'h80, 1'b0, 1'b0, 4'd10, 1'b1},
    row_t'{8'h24, 1'b0, 1'b0, 4'd5,  1'b1},
    row_t'{8'h00, 1'b1, 1'b0, 4'd1,  1'b0},
    row_t'{8'h00, 1'b0, 1'b1, 4'd2,  1'b1},
    row_t'{8'hFF, 1'b1, 1'b1, 4'd1,  1'b0},
    row_t'{8'h10, 1'b0, 1'b1, 4'd2,  1'b1},
    row_t'{8'h06, 1'b0, 1'b0, 4'd4,  1'b1}
  };

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [ADDR_W-1:0] pc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mode == 1'b0 && pending == '0 && !masked, "R1 mode/pending/mask", {mode, pending, masked}, 0);
    check(!stall && !redirect && epc == '0 && cause == '0, "R1 stall/redirect/epc", {stall, redirect, epc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: boot return from monitor into user at saved address 0
    do_return("boot", 0);

    for (int i = 0; i < NROWS; i++) begin
      pc = 16'h0100 + ADDR_W'(i * 16);
      irq = ROWS[i].irqs;
      @(negedge clk);
      irq = '0;
      do_retire(pc, ROWS[i].f, ROWS[i].s, 1'b0);
      check_entry($sformatf("row%0d", i), ROWS[i].cause, ROWS[i].use_next ? pc + 1 : pc);
      ack_all();
      check(pending == '0, "R7 ack clears all", pending, 0);
      do_return($sformatf("row%0d", i), ROWS[i].use_next ? pc + 1 : pc);
    end

    // R3: pending line without retire is not taken
    irq = 8'h02;
    @(negedge clk);
    irq = '0;
    quiet(4, "R3 no retire no trap");
    check(pending == 8'h02, "R7 sticky", pending, 8'h02);
    do_retire(16'h0300, 1'b0, 1'b0, 1'b0);
    check_entry("R3 taken at boundary", 4, 16'h0301);

    // R6: masked while in service
    irq = 8'h08;
    @(negedge clk);
    irq = '0;
    do_retire(16'h0500, 1'b0, 1'b0, 1'b0);
    quiet(1, "R6 masked retire a");
    do_retire(16'h0501, 1'b0, 1'b0, 1'b0);
    quiet(2, "R6 masked retire b");
    check(pending == 8'h0A, "R6/R7 pending held", pending, 8'h0A);
    ack = 1'b1; ack_cause = 4'd4;
    @(negedge clk);
    ack = 1'b0;
    check(pending == 8'h08, "R7 selective ack", pending, 8'h08);
    do_return("R6 unmask", 16'h0301);
    do_retire(16'h0310, 1'b0, 1'b0, 1'b0);
    check_entry("R6 after return", 6, 16'h0311);
    ack_all();
    do_return("R6 second", 16'h0311);

    // R7: set wins over same-cycle ack
    irq = 8'h40; ack = 1'b1; ack_cause = 4'd9;
    @(negedge clk);
    irq = '0; ack = 1'b0;
    check(pending == 8'h40, "R7 set wins", pending, 8'h40);
    ack = 1'b1; ack_cause = 4'd9;
    @(negedge clk);
    ack = 1'b0;
    check(pending == 8'h00, "R7 ack clears", pending, 0);
    do_retire(16'h0320, 1'b0, 1'b0, 1'b0);
    quiet(3, "R7 cleared line not taken");
    check(mode == 1'b1, "R7 still user", mode, 1);

    // R9: return from user mode traps
    do_retire(16'h0330, 1'b0, 1'b0, 1'b1);
    check_entry("R9 user return", 0, 16'h0330);
    do_return("R9 back", 16'h0330);

    finish_run();
  end

endmodule